// File: doc/BRIEF.md
# Flash Read Access Arbiter

This block sits between two read requesters and a flash array. One requester fetches instructions, the other fetches data. When the memory side is idle, the block grants one pending request. The data port wins whenever both ports ask in the same cycle. The block latches the winner's address and drives the array's read enable for a programmable number of cycles. It then hands the captured word to the winner with a one-cycle valid strobe.

A busy input reports a program or erase operation in progress. A read that is granted while busy is high is held back and not refused. It is issued with its full wait-state count once busy drops. A port that has nothing outstanding is never affected by busy.

The wait-state count comes from a 3-bit register that software loads through a write strobe. The count is sampled when a read is issued, so rewriting it cannot stretch or shorten a read already on the array.

Top module: `flashReadArb`

## Requirements
- R1: In reset and after it with no request pending, `flashRen`, `instValid` and `dataValid` are low, and both ready outputs are high.
- R2: The latency register resets to 0, so the first read after reset holds `flashRen` for exactly one cycle. A cycle with `latWrEn` high loads `latWrData` into the register.
- R3: A read issued with latency value N keeps `flashRen` high and `flashAddr` unchanged for exactly N+1 consecutive cycles, with `flashAddr` equal to the granted port's address.
- R4: In the cycle right after the last `flashRen` cycle, only the winning port's valid is high, for one cycle. Its read data equals `{addr, ~addr}` as returned by the array for that address.
- R5: When both ports request in the same idle cycle, the data port's read is served first.
- R6: A granted read is never preempted. A data request that arrives while a prefetch read is in flight is served only after that read's valid.
- R7: A latency write that lands while a read is in flight leaves that read's hold length unchanged. The new value applies from the next issued read.
- R8: A granted read is not issued while `flashBusy` is high, whether busy was high before the grant or rose after it. Once busy is low, the read is issued with its full N+1 hold. A read already on the array completes regardless of busy.
- R9: A port's ready is low from the cycle its request is raised until its valid cycle, including every stalled cycle. Ready is high in the valid cycle and whenever the port has no request.
- R10: While busy is high, a port with no request keeps ready high and valid low.
- R11: A new grant happens only when the memory side is idle, so no read is issued in the cycle after a valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| latWrEn | input | 1 | Load strobe for the latency register |
| latWrData | input | 3 | New latency value |
| instReq | input | 1 | Prefetch port read request, held until valid |
| instAddr | input | 16 | Prefetch port read address |
| instReady | output | 1 | Prefetch port ready |
| instValid | output | 1 | Prefetch port data valid, one cycle |
| instRdata | output | 32 | Prefetch port read data |
| dataReq | input | 1 | Data port read request, held until valid |
| dataAddr | input | 16 | Data port read address |
| dataReady | output | 1 | Data port ready |
| dataValid | output | 1 | Data port data valid, one cycle |
| dataRdata | output | 32 | Data port read data |
| flashAddr | output | 16 | Array address |
| flashRen | output | 1 | Array read enable |
| flashRdata | input | 32 | Array read data |
| flashBusy | input | 1 | Program or erase in progress |

## Verification
The embedded assertions watch on every cycle that:
- the array address stays put during a hold;
- valid is one-hot and lasts one cycle;
- valid follows the end of a hold;
- no read starts in a cycle where busy was high;
- no read is issued straight after a delivery.

Other behaviours depend on history and need the bench's scenarios and its per-cycle reference model:
- the exact N+1 hold length;
- data-over-prefetch ordering;
- the absence of preemption;
- the latency-change timing;
- the full count after a busy stall.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;

  localparam int PORT_INST = 0;
  localparam int PORT_DATA = 1;
  localparam int NUM_PORTS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_HOLD,
    ST_DONE
  } arbState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchAddr;  // grant: capture owner and address
    logic pickData;   // winner is the data port
    logic issueRen;   // drive the array read enable
    logic capture;    // last hold cycle: capture array data
    logic deliver;    // valid cycle towards the owner
  } arbStrobe_t;

endpackage

// File: rtl/farb_ctrl.sv
module farb_ctrl
  import flash_arb_pkg::*;
#(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             latWrEn,
  input  logic [LAT_W-1:0] latWrData,
  input  logic             instReq,
  input  logic             dataReq,
  input  logic             flashBusy,
  output arbStrobe_t       strobe
);

  arbState_t        state, stateNext;
  logic [LAT_W-1:0] latReg;
  logic [LAT_W-1:0] holdCnt;
  logic             anyReq;
  logic             lastHold;
  logic             issueNow;

  always_comb begin
    anyReq    = instReq | dataReq;
    lastHold  = (state == ST_HOLD) && (holdCnt == '0);
    issueNow  = (state == ST_PEND) && !flashBusy;
    stateNext = state;
    case (state)
      ST_IDLE: if (anyReq)   stateNext = ST_PEND;
      ST_PEND: if (issueNow) stateNext = ST_HOLD;
      ST_HOLD: if (lastHold) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  // Latency register, zero after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      latReg <= '0;
    end else if (latWrEn) begin
      latReg <= latWrData;
    end
  end

  // State and wait-state counter; count sampled only at issue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      state <= stateNext;
      if (issueNow) begin
        holdCnt <= latReg;
      end else if ((state == ST_HOLD) && !lastHold) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.latchAddr = (state == ST_IDLE) && anyReq;
    strobe.pickData  = dataReq;
    strobe.issueRen  = (state == ST_HOLD);
    strobe.capture   = lastHold;
    strobe.deliver   = (state == ST_DONE);
  end

  // R8: a hold never starts in a cycle that followed busy
  a_r8_issue_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.issueRen) |-> !$past(flashBusy));

  // R11: after a delivery the array is idle for at least one cycle
  a_r11_idle_after_deliver: assert property (@(posedge clk) disable iff (!rstN)
    strobe.deliver |=> (!strobe.issueRen && !strobe.deliver));

endmodule

// File: rtl/farb_dp.sv
module farb_dp
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  arbStrobe_t                      strobe,
  input  logic [NUM_PORTS-1:0]            portReq,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] portAddr,
  output logic [NUM_PORTS-1:0]            portValid,
  output logic [NUM_PORTS-1:0]            portReady,
  output logic [DATA_W-1:0]               rdOut,
  output logic [ADDR_W-1:0]               flashAddr,
  output logic                            flashRen,
  input  logic [DATA_W-1:0]               flashRdata
);

  localparam int OWN_W = $clog2(NUM_PORTS);

  logic [OWN_W-1:0]  owner;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] rdataReg;
  logic              validAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner    <= '0;
      addrReg  <= '0;
      rdataReg <= '0;
    end else begin
      if (strobe.latchAddr) begin
        owner   <= OWN_W'(strobe.pickData);
        addrReg <= portAddr[strobe.pickData];
      end
      if (strobe.capture) begin
        rdataReg <= flashRdata;
      end
    end
  end

  assign flashAddr = addrReg;
  assign flashRen  = strobe.issueRen;
  assign rdOut     = rdataReg;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign portValid[p] = strobe.deliver && (owner == OWN_W'(p));
    assign portReady[p] = !portReq[p] || portValid[p];
  end

  assign validAny = |portValid;

  // R3: address frozen while the read enable is held
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (flashRen && $past(flashRen)) |-> $stable(flashAddr));

  // R4: at most one port valid
  a_r4_onehot_valid: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portValid));

  // R4: valid lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    validAny |=> !validAny);

  // R4: valid comes right after the last hold cycle
  a_r4_after_hold: assert property (@(posedge clk) disable iff (!rstN)
    validAny |-> ($past(flashRen) && !flashRen));

endmodule

// File: rtl/flashReadArb.sv
module flashReadArb
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latWrEn,
  input  logic [LAT_W-1:0]  latWrData,
  input  logic              instReq,
  input  logic [ADDR_W-1:0] instAddr,
  output logic              instReady,
  output logic              instValid,
  output logic [DATA_W-1:0] instRdata,
  input  logic              dataReq,
  input  logic [ADDR_W-1:0] dataAddr,
  output logic              dataReady,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataRdata,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashRen,
  input  logic [DATA_W-1:0] flashRdata,
  input  logic              flashBusy
);

  arbStrobe_t                       strobe;
  logic [NUM_PORTS-1:0]             portReq;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] portAddr;
  logic [NUM_PORTS-1:0]             portValid;
  logic [NUM_PORTS-1:0]             portReady;
  logic [DATA_W-1:0]                rdOut;

  assign portReq[PORT_INST]  = instReq;
  assign portReq[PORT_DATA]  = dataReq;
  assign portAddr[PORT_INST] = instAddr;
  assign portAddr[PORT_DATA] = dataAddr;

  farb_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .latWrEn   (latWrEn),
    .latWrData (latWrData),
    .instReq   (instReq),
    .dataReq   (dataReq),
    .flashBusy (flashBusy),
    .strobe    (strobe)
  );

  farb_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .portReq    (portReq),
    .portAddr   (portAddr),
    .portValid  (portValid),
    .portReady  (portReady),
    .rdOut      (rdOut),
    .flashAddr  (flashAddr),
    .flashRen   (flashRen),
    .flashRdata (flashRdata)
  );

  assign instValid = portValid[PORT_INST];
  assign dataValid = portValid[PORT_DATA];
  assign instReady = portReady[PORT_INST];
  assign dataReady = portReady[PORT_DATA];
  assign instRdata = rdOut;
  assign dataRdata = rdOut;

endmodule

// File: tb/test_flashReadArb.sv
`timescale 1ns/1ps
module test_flashReadArb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          latWrEn = 1'b0;
  logic [LW-1:0] latWrData = '0;
  logic          instReq = 1'b0, dataReq = 1'b0;
  logic [AW-1:0] instAddr = '0, dataAddr = '0;
  logic          instReady, instValid, dataReady, dataValid;
  logic [DW-1:0] instRdata, dataRdata, flashRdata;
  logic [AW-1:0] flashAddr;
  logic          flashRen;
  logic          flashBusy = 1'b0;

  assign flashRdata = {flashAddr, ~flashAddr};

  flashReadArb i_flashReadArb (
    .clk(clk), .rstN(rstN), .latWrEn(latWrEn), .latWrData(latWrData),
    .instReq(instReq), .instAddr(instAddr), .instReady(instReady),
    .instValid(instValid), .instRdata(instRdata),
    .dataReq(dataReq), .dataAddr(dataAddr), .dataReady(dataReady),
    .dataValid(dataValid), .dataRdata(dataRdata),
    .flashAddr(flashAddr), .flashRen(flashRen),
    .flashRdata(flashRdata), .flashBusy(flashBusy)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 waiting, 2 holding, 3 delivering
  int            mPhase = 0, mOwner = 0, mLeft = 0, mLat = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mData = '0;
  int            expRuns[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mOwner = 0; mLeft = 0; mLat = 0;
      expRuns.delete();
    end else begin
      case (mPhase)
        0: if (dataReq) begin mOwner = 1; mAddr = dataAddr; mPhase = 1; end
           else if (instReq) begin mOwner = 0; mAddr = instAddr; mPhase = 1; end
        1: if (!flashBusy) begin mLeft = mLat; expRuns.push_back(mLat + 1); mPhase = 2; end
        2: if (mLeft == 0) begin mData = {mAddr, ~mAddr}; mPhase = 3; end
           else mLeft--;
        default: mPhase = 0;
      endcase
      if (latWrEn) mLat = int'(latWrData);
    end
  end

  int            runLen = 0, lastRun = 0, firstValid = -1;
  int            instLeft = 0, dataLeft = 0;
  logic [AW-1:0] instNext = 16'h1000, dataNext = 16'h8000;
  logic          eRen, eVi, eVd;
  int            expRun;

  // Per-cycle compare, then requester drivers
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        eRen = (mPhase == 2);
        eVi  = (mPhase == 3) && (mOwner == 0);
        eVd  = (mPhase == 3) && (mOwner == 1);
        chk(flashRen === eRen, "R3 R8 R11 flashRen", 64'(flashRen), 64'(eRen));
        if (eRen) chk(flashAddr === mAddr, "R3 flashAddr", 64'(flashAddr), 64'(mAddr));
        chk(instValid === eVi, "R4 R6 instValid", 64'(instValid), 64'(eVi));
        chk(dataValid === eVd, "R4 R5 dataValid", 64'(dataValid), 64'(eVd));
        if (eVi) chk(instRdata === mData, "R4 instRdata", 64'(instRdata), 64'(mData));
        if (eVd) chk(dataRdata === mData, "R4 dataRdata", 64'(dataRdata), 64'(mData));
        chk(instReady === (!instReq || eVi), "R9 R10 instReady", 64'(instReady), 64'(!instReq || eVi));
        chk(dataReady === (!dataReq || eVd), "R9 R10 dataReady", 64'(dataReady), 64'(!dataReq || eVd));
        if (flashRen === 1'b1) runLen++;
        else if (runLen > 0) begin
          lastRun = runLen;
          expRun = (expRuns.size() > 0) ? expRuns.pop_front() : -1;
          chk(runLen == expRun, "R3 hold length", 64'(runLen), 64'(expRun));
          runLen = 0;
        end
        if (firstValid < 0) begin
          if (dataValid) firstValid = 1;
          else if (instValid) firstValid = 0;
        end
        // requester drivers
        if (instReq && instValid) begin
          if (instLeft > 0) begin instAddr = instNext; instNext++; instLeft--; end
          else instReq = 1'b0;
        end else if (!instReq && instLeft > 0) begin
          instReq = 1'b1; instAddr = instNext; instNext++; instLeft--;
        end
        if (dataReq && dataValid) begin
          if (dataLeft > 0) begin dataAddr = dataNext; dataNext++; dataLeft--; end
          else dataReq = 1'b0;
        end else if (!dataReq && dataLeft > 0) begin
          dataReq = 1'b1; dataAddr = dataNext; dataNext++; dataLeft--;
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (instLeft != 0 || dataLeft != 0 || instReq || dataReq);
    repeat (3) @(negedge clk);
  endtask

  task automatic setLat(input int v);
    @(negedge clk);
    latWrEn = 1'b1; latWrData = LW'(v);
    @(negedge clk);
    latWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!flashRen && !instValid && !dataValid, "R1 reset outputs low",
        64'({flashRen, instValid, dataValid}), 64'(0));
    chk(instReady && dataReady, "R1 reset ready high", 64'({instReady, dataReady}), 64'(3));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!flashRen && instReady && dataReady, "R1 idle after reset",
        64'({flashRen, instReady, dataReady}), 64'(3));

    // R2: default latency gives one-cycle hold
    instLeft = 1; waitIdle();
    chk(lastRun == 1, "R2 reset latency hold", 64'(lastRun), 64'(1));

    // R2 R3: programmed latency 3
    setLat(3); dataLeft = 1; waitIdle();
    chk(lastRun == 4, "R2 R3 latency 3 hold", 64'(lastRun), 64'(4));

    // R5: simultaneous requests
    firstValid = -1; instLeft = 1; dataLeft = 1; waitIdle();
    chk(firstValid == 1, "R5 data port first", 64'(firstValid), 64'(1));

    // R6: data request during prefetch read
    setLat(5); firstValid = -1; instLeft = 1;
    repeat (3) @(negedge clk);
    dataLeft = 1; waitIdle();
    chk(firstValid == 0, "R6 no preemption", 64'(firstValid), 64'(0));

    // R7: latency rewritten mid-read
    setLat(2); instLeft = 1;
    repeat (3) @(negedge clk);
    setLat(6); waitIdle();
    chk(lastRun == 3, "R7 in-flight read keeps old latency", 64'(lastRun), 64'(3));
    instLeft = 1; waitIdle();
    chk(lastRun == 7, "R7 next read uses new latency", 64'(lastRun), 64'(7));

    // R8: busy before request
    @(negedge clk); flashBusy = 1'b1; instLeft = 1;
    repeat (6) @(negedge clk);
    chk(!flashRen, "R8 stalled while busy", 64'(flashRen), 64'(0));
    chk(!instReady, "R8 R9 ready low while stalled", 64'(instReady), 64'(0));
    flashBusy = 1'b0; waitIdle();
    chk(lastRun == 7, "R8 full hold after busy", 64'(lastRun), 64'(7));

    // R8: busy rises after grant
    setLat(1); dataLeft = 1;
    do @(negedge clk); while (!dataReq);
    flashBusy = 1'b1;
    repeat (4) @(negedge clk);
    chk(!flashRen, "R8 granted read waits for busy", 64'(flashRen), 64'(0));
    flashBusy = 1'b0; waitIdle();
    chk(lastRun == 2, "R8 full hold after late busy", 64'(lastRun), 64'(2));

    // R10: busy with no requests
    flashBusy = 1'b1;
    repeat (8) @(negedge clk);
    chk(instReady && dataReady && !instValid && !dataValid, "R10 idle ports unaffected",
        64'({instReady, dataReady, instValid, dataValid}), 64'(12));
    flashBusy = 1'b0;

    // Mixed traffic
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (instLeft == 0 && $urandom_range(0, 5) == 0) instLeft = $urandom_range(1, 3);
      if (dataLeft == 0 && $urandom_range(0, 6) == 0) dataLeft = $urandom_range(1, 3);
      if ($urandom_range(0, 15) == 0) flashBusy = ~flashBusy;
      latWrEn = ($urandom_range(0, 20) == 0);
      latWrData = LW'($urandom_range(0, 7));
    end
    @(negedge clk);
    latWrEn = 1'b0; flashBusy = 1'b0;
    waitIdle();
    chk(expRuns.size() == 0, "R3 every issued read completed", 64'(expRuns.size()), 64'(0));
    summary();
  end

endmodule